// File: doc/BRIEF.md
# Burst ROM Read Controller

This block reads a run of sequential words from an external ROM that supports fast page reads. One accepted request produces a full-length first access, followed by 0 to 63 short burst accesses. Each burst access moves to the next word in the same page. Chip select and read strobe stay active for the whole run. Only the low address bits advance from word to word.

The first access has the timing of an ordinary bus read. It takes 2 basic cycles, or 3 plus a programmed wait of 0 to 7 cycles. In the 3-cycle mode the external wait input can stretch it further. Each later word takes a separately programmed 1 to 8 cycles, and the wait input has no effect on it. An optional extra cycle of chip select can follow the last read. Every word is returned on an output port together with a one-cycle valid flag. The request port stays closed until the run has fully ended.

Top module: `burst_rom_rd`

## Requirements
- R1: After reset `mem_sel`, `mem_rd`, `out_valid` and `busy` are all low.
- R2: The first access lasts 2 cycles when `cfg_three_state`=0, whatever `cfg_wait_prog` holds. It lasts 3+`cfg_wait_prog` cycles when `cfg_three_state`=1.
- R3: With `cfg_three_state`=1, every cycle in which `mem_wait_in` is high during the final cycle of the first access adds one cycle to that access. With `cfg_three_state`=0 the wait input is ignored.
- R4: Exactly `req_count` burst accesses (0 to 63) follow the first access, and each lasts `cfg_burst_len`+1 cycles.
- R5: `mem_rd` is high without a break from the cycle after acceptance through the end of the last access, and `mem_sel` is high whenever `mem_rd` is.
- R6: The first access uses `req_addr`. At the start of each burst access, bits [LOWB-1:0] of `mem_addr` increase by one and wrap to zero within the page, while bits [AW-1:LOWB] stay at their starting value.
- R7: `mem_wait_in` has no effect on the length of a burst access.
- R8: `out_valid` is a one-cycle pulse in the cycle after each access ends. `out_data` then holds `mem_data_in` as sampled on that access's final clock edge, which gives `req_count`+1 pulses per run.
- R9: With `cfg_cs_ext`=1, `mem_sel` stays high for one cycle after `mem_rd` falls. With `cfg_cs_ext`=0, both fall together.
- R10: The number of cycles `mem_sel` is high equals the first-access length, plus added wait cycles, plus `req_count`×(`cfg_burst_len`+1), plus `cfg_cs_ext`.
- R11: `busy` is high from acceptance until the last `out_valid` has been given and `mem_sel` is low. A `req_valid` seen while `busy` is high is dropped and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Start a run; taken when `busy` is low |
| req_addr | input | AW | Word address of the first access |
| req_count | input | 6 | Number of burst accesses after the first |
| cfg_three_state | input | 1 | 1: 3 basic cycles with waits allowed; 0: 2 cycles, no waits |
| cfg_wait_prog | input | 3 | Programmed wait cycles for the first access |
| cfg_cs_ext | input | 1 | Hold chip select one cycle after the last read |
| cfg_burst_len | input | 3 | Burst access length minus one |
| busy | output | 1 | Run in progress; requests are refused |
| mem_addr | output | AW | ROM word address |
| mem_sel | output | 1 | ROM chip select, active high |
| mem_rd | output | 1 | ROM read strobe, active high |
| mem_wait_in | input | 1 | External wait request |
| mem_data_in | input | DW | ROM read data |
| out_valid | output | 1 | Word available |
| out_data | output | DW | Word read |

## Verification
Take the cycle right after the accepting edge as cycle 0. Let L be the first-access length, x the number of added wait cycles, K the burst length, N the burst count and E the extension. Then word i must show `out_valid` in cycle L+x+i·K. `mem_rd` must be high in cycles 0 to L+x+N·K−1, and `mem_sel` in cycles 0 to L+x+N·K+E−1. `busy` must be low by cycle L+x+N·K+E+1.

The bench works these numbers out for each scenario and samples every output on the falling edge of each of those cycles. The emulated ROM returns a word derived from its address, so each word's expected value also checks the address sequence.

// File: rtl/brr_pkg.sv
package brr_pkg;

    localparam int WAIT_W  = 3;
    localparam int BLEN_W  = 3;
    localparam int COUNT_W = 6;
    localparam int TMR_W   = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FULL  = 2'd1,
        ST_BURST = 2'd2,
        ST_CSEXT = 2'd3
    } brr_state_e;

    typedef struct packed {
        logic              three_state;
        logic [WAIT_W-1:0] wait_prog;
        logic              cs_ext;
        logic [BLEN_W-1:0] burst_len;
    } brr_cfg_t;

    // Timer reload for the first access: length minus one.
    function automatic logic [TMR_W-1:0] full_reload(input brr_cfg_t c);
        if (c.three_state)
            full_reload = TMR_W'(2) + TMR_W'(c.wait_prog);
        else
            full_reload = TMR_W'(1);
    endfunction

    // Timer reload for a burst access: length minus one.
    function automatic logic [TMR_W-1:0] burst_reload(input brr_cfg_t c);
        burst_reload = TMR_W'(c.burst_len);
    endfunction

endpackage

// File: rtl/brr_timer.sv
module brr_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/brr_addr_gen.sv
module brr_addr_gen #(
    parameter int AW   = 20,
    parameter int LOWB = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic          step,
    output logic [AW-1:0] addr
);
    always_ff @(posedge clk) begin
        if (rst)
            addr <= '0;
        else if (load)
            addr <= load_addr;
        else if (step)
            addr[LOWB-1:0] <= addr[LOWB-1:0] + 1'b1;
    end

endmodule

// File: rtl/brr_capture.sv
module brr_capture #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          take,
    input  logic [DW-1:0] din,
    output logic          valid,
    output logic [DW-1:0] dout
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            dout  <= '0;
        end else begin
            valid <= take;
            if (take)
                dout <= din;
        end
    end

endmodule

// File: rtl/burst_rom_rd.sv
module burst_rom_rd
    import brr_pkg::*;
#(
    parameter int AW   = 20,
    parameter int DW   = 16,
    parameter int LOWB = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    input  logic [AW-1:0]         req_addr,
    input  logic [COUNT_W-1:0]    req_count,
    input  logic                  cfg_three_state,
    input  logic [WAIT_W-1:0]     cfg_wait_prog,
    input  logic                  cfg_cs_ext,
    input  logic [BLEN_W-1:0]     cfg_burst_len,
    output logic                  busy,
    output logic [AW-1:0]         mem_addr,
    output logic                  mem_sel,
    output logic                  mem_rd,
    input  logic                  mem_wait_in,
    input  logic [DW-1:0]         mem_data_in,
    output logic                  out_valid,
    output logic [DW-1:0]         out_data
);
    brr_state_e         state;
    brr_cfg_t           cfg_q;
    brr_cfg_t           cfg_in;
    logic [COUNT_W-1:0] left;
    logic               accept;
    logic               stall;
    logic               full_done;
    logic               burst_done;
    logic               acc_done;
    logic               go_burst;
    logic               tmr_load;
    logic [TMR_W-1:0]   tmr_val;
    logic               tmr_expired;

    assign cfg_in = '{three_state: cfg_three_state, wait_prog: cfg_wait_prog,
                      cs_ext: cfg_cs_ext, burst_len: cfg_burst_len};

    assign busy       = (state != ST_IDLE) || out_valid;
    assign accept     = req_valid && !busy;
    assign stall      = cfg_q.three_state && mem_wait_in;
    assign full_done  = (state == ST_FULL) && tmr_expired && !stall;
    assign burst_done = (state == ST_BURST) && tmr_expired;
    assign acc_done   = full_done || burst_done;
    assign go_burst   = acc_done && (left != '0);
    assign tmr_load   = accept || go_burst;
    assign tmr_val    = accept ? full_reload(cfg_in) : burst_reload(cfg_q);

    assign mem_sel = (state != ST_IDLE);
    assign mem_rd  = (state == ST_FULL) || (state == ST_BURST);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cfg_q <= '0;
            left  <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        state <= ST_FULL;
                        cfg_q <= cfg_in;
                        left  <= req_count;
                    end
                end
                ST_FULL, ST_BURST: begin
                    if (go_burst) begin
                        state <= ST_BURST;
                        left  <= left - 1'b1;
                    end else if (acc_done) begin
                        state <= cfg_q.cs_ext ? ST_CSEXT : ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    brr_timer #(.W(TMR_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    brr_addr_gen #(.AW(AW), .LOWB(LOWB)) u_addr (
        .clk       (clk),
        .rst       (rst),
        .load      (accept),
        .load_addr (req_addr),
        .step      (go_burst),
        .addr      (mem_addr)
    );

    brr_capture #(.DW(DW)) u_cap (
        .clk   (clk),
        .rst   (rst),
        .take  (acc_done),
        .din   (mem_data_in),
        .valid (out_valid),
        .dout  (out_data)
    );

    // R5: read strobe only inside chip select
    a_r5_rd_in_sel: assert property (@(posedge clk) disable iff (rst)
        mem_rd |-> mem_sel);

    // R6: page bits fixed for the whole run
    a_r6_page_held: assert property (@(posedge clk) disable iff (rst)
        (mem_sel && $past(mem_sel)) |-> $stable(mem_addr[AW-1:LOWB]));

    // R6: low bits step by one into each burst access
    a_r6_low_step: assert property (@(posedge clk) disable iff (rst)
        (go_burst) |=> (mem_addr[LOWB-1:0] == $past(mem_addr[LOWB-1:0]) + 1'b1));

    // R7: wait input cannot stretch a burst access
    a_r7_burst_no_wait: assert property (@(posedge clk) disable iff (rst)
        (state == ST_BURST && tmr_expired && mem_wait_in) |=> out_valid);

    // R8: each word follows a read cycle
    a_r8_valid_after_rd: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(mem_rd));

    // R9: extension keeps select one cycle past the strobe
    a_r9_ext_on: assert property (@(posedge clk) disable iff (rst)
        ($fell(mem_rd) && cfg_q.cs_ext) |-> (mem_sel ##1 !mem_sel));
    a_r9_ext_off: assert property (@(posedge clk) disable iff (rst)
        ($fell(mem_rd) && !cfg_q.cs_ext) |-> !mem_sel);

    // R11: no fresh first access while a run is active
    a_r11_no_restart: assert property (@(posedge clk) disable iff (rst)
        (busy && req_valid) |=> !(state == ST_FULL && $past(state) != ST_FULL && $past(state) != ST_IDLE));

endmodule

// File: tb/burst_rom_rd_tb.sv
module burst_rom_rd_tb;
    localparam int AW   = 20;
    localparam int DW   = 16;
    localparam int LOWB = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [5:0]    req_count = '0;
    logic          cfg_three_state = 1'b0;
    logic [2:0]    cfg_wait_prog = '0;
    logic          cfg_cs_ext = 1'b0;
    logic [2:0]    cfg_burst_len = '0;
    logic          busy;
    logic [AW-1:0] mem_addr;
    logic          mem_sel;
    logic          mem_rd;
    logic          mem_wait_in = 1'b0;
    logic [DW-1:0] mem_data_in;
    logic          out_valid;
    logic [DW-1:0] out_data;

    int n_checks = 0;
    int n_errors = 0;

    always #10 clk = ~clk;

    // ROM model: word is a function of its address
    function automatic logic [DW-1:0] rom_word(input logic [AW-1:0] a);
        return a[DW-1:0] ^ 16'h5A3C;
    endfunction
    assign mem_data_in = rom_word(mem_addr);

    burst_rom_rd #(.AW(AW), .DW(DW), .LOWB(LOWB)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_count(req_count), .cfg_three_state(cfg_three_state),
        .cfg_wait_prog(cfg_wait_prog), .cfg_cs_ext(cfg_cs_ext),
        .cfg_burst_len(cfg_burst_len), .busy(busy), .mem_addr(mem_addr),
        .mem_sel(mem_sel), .mem_rd(mem_rd), .mem_wait_in(mem_wait_in),
        .mem_data_in(mem_data_in), .out_valid(out_valid), .out_data(out_data)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One run: drives request, waits, optional stray request; checks all outputs per cycle.
    task automatic run_read(input logic [AW-1:0] a, input int n, input bit three,
                            input int w, input bit ext, input int blen,
                            input int wf, input int wt, input int extra, input int poke);
        int L, K, T, first, sel_bad, rd_bad, busy_bad, up_bad, nvalid, data_bad, time_bad;
        logic [AW-1:0] exp_a;
        L = three ? 3 + w : 2;
        K = blen + 1;
        first = L + extra;
        T = first + n * K + (ext ? 1 : 0);
        sel_bad = 0; rd_bad = 0; busy_bad = 0; up_bad = 0;
        nvalid = 0; data_bad = 0; time_bad = 0;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr = a;
        req_count = 6'(n);
        cfg_three_state = three;
        cfg_wait_prog = 3'(w);
        cfg_cs_ext = ext;
        cfg_burst_len = 3'(blen);
        for (int c = 0; c <= T + 2; c++) begin
            @(negedge clk);
            req_valid = (c == poke);
            if (c == poke) begin
                req_addr = a ^ 20'hF0F0F;
                req_count = 6'd1;
                cfg_three_state = 1'b0;
                cfg_burst_len = 3'd0;
                cfg_cs_ext = 1'b0;
            end
            mem_wait_in = (c >= wf && c < wt);
            if (mem_sel != (c < T)) sel_bad++;
            if (mem_rd != (c < T - (ext ? 1 : 0))) rd_bad++;
            if (c < T && busy != 1'b1) busy_bad++;
            if (c == T + 1 && busy != 1'b0) busy_bad++;
            if (mem_sel && mem_addr[AW-1:LOWB] != a[AW-1:LOWB]) up_bad++;
            if (out_valid) begin
                if (c != first + nvalid * K) time_bad++;
                exp_a = {a[AW-1:LOWB], LOWB'(a[LOWB-1:0] + LOWB'(nvalid))};
                if (out_data != rom_word(exp_a)) data_bad++;
                nvalid++;
            end
        end
        req_valid = 1'b0;
        mem_wait_in = 1'b0;
        check(sel_bad == 0, "R10 select window length", sel_bad, 0);
        check(rd_bad == 0, "R5 read strobe window", rd_bad, 0);
        check(nvalid == n + 1, "R4 word count", nvalid, n + 1);
        check(time_bad == 0, "R8 valid timing (R2/R3 first length)", time_bad, 0);
        check(data_bad == 0, "R6 word addresses", data_bad, 0);
        check(up_bad == 0, "R6 page bits held", up_bad, 0);
        check(busy_bad == 0, "R11 busy window", busy_bad, 0);
        repeat (2) @(negedge clk);
    endtask

    task automatic test_reset();
        @(negedge clk);
        check(mem_sel == 1'b0, "R1 sel", int'(mem_sel), 0);
        check(mem_rd == 1'b0, "R1 rd", int'(mem_rd), 0);
        check(out_valid == 1'b0, "R1 valid", int'(out_valid), 0);
        check(busy == 1'b0, "R1 busy", int'(busy), 0);
    endtask

    initial begin : watchdog
        #(20 * 150000);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        test_reset();
        // R2: two-state ignores programmed wait
        run_read(20'h12340, 0, 1'b0, 5, 1'b0, 0, 99, 99, 0, -1);
        // R2 R4 R9: three-state with waits, three bursts, extension
        run_read(20'h0ABC1, 3, 1'b1, 2, 1'b1, 2, 99, 99, 0, -1);
        // R3: wait pin stretches last full cycle by 3
        run_read(20'h55550, 2, 1'b1, 0, 1'b0, 0, 0, 5, 3, -1);
        // R3: wait pin ignored in two-state
        run_read(20'h77773, 1, 1'b0, 0, 1'b1, 7, 0, 6, 0, -1);
        // R7: wait during bursts only, low-bit wrap
        run_read(20'hABCDE, 4, 1'b1, 1, 1'b0, 1, 5, 30, 0, -1);
        // R4 R10 R11: longest run with stray request
        run_read(20'h3C3C0, 63, 1'b1, 7, 1'b1, 7, 99, 99, 0, 100);
        // R11: stray request in last delivery cycle
        run_read(20'h00002, 1, 1'b0, 0, 1'b0, 0, 99, 99, 0, 3);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule